// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on a single line, TxD. A nine-bit control register sets the framing: how many data bits to send, whether a parity bit is added and of which sense, and how many stop bits close the character. The same register also gates the transmitter, forces a continuous break (spacing level), and drives an active-low data-terminal-ready pin. Bytes enter through a valid/ready handshake. A new byte is taken only when no character is in flight.

Bit timing comes from an external enable, `tick`. With `x16_mode` high, each bit lasts `BIT_TICKS` (16) ticks, and a one-and-a-half stop period lasts 24 ticks. With `x16_mode` low, each bit lasts a single tick. The half-stop setting has no meaning in 1x mode. In that case the block raises `cfg_err` and sends one stop bit. A channel reset clears the whole control register. This turns the transmitter off and releases DTR.

Control register layout (`ctl_wdata`): bit 0 enable, bit 1 break, bit 2 DTR, bit 3 parity enable, bit 4 parity sense (1 = even), bits 6:5 length code, bits 8:7 stop code.

Top module: `async_tx_framer`

## Requirements
- R1: After reset, and with the control register at zero, `txd` = 1, `dtr_n` = 1, `tx_idle` = 1, `din_ready` = 0 and `cfg_err` = 0.
- R2: A character is sent as follows. One low start bit comes first. The data bits follow, least significant bit first. High stop bits close the character, and the line idles high afterwards. In 1x mode each bit lasts exactly one tick. Cycles without `tick` do not advance the line.
- R3: The length code in bits 6:5 selects the number of data bits: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8. Data bits above the selected length are not sent.
- R4: With bit 3 set, one parity bit follows the last data bit. When bit 4 is 1, the parity bit makes the count of ones in the data bits plus the parity bit even. When bit 4 is 0, it makes that count odd. With bit 3 clear, bit 4 has no effect on the line.
- R5: The stop code in bits 8:7 sets the stop period: 01 gives one stop bit, 10 gives one and a half, and 11 gives two. Code 00 disables the transmitter: `txd` = 1 and `din_ready` = 0.
- R6: In 16x mode every bit lasts 16 ticks, and the one-and-a-half stop period lasts 24 ticks.
- R7: In 1x mode with stop code 10, `cfg_err` = 1 and exactly one stop bit of one tick is sent. In 16x mode `cfg_err` = 0.
- R8: While bit 1 (break) is set, `txd` = 0 and `din_ready` = 0, and any character in flight is abandoned (`tx_idle` = 1 one cycle later). When the bit is cleared, the line returns high.
- R9: While bit 0 (enable) is clear, `txd` = 1, `din_ready` = 0 and `tx_idle` = 1.
- R10: With bit 2 set, `dtr_n` = 0. With bit 2 clear, `dtr_n` = 1. A `chan_rst` pulse clears the whole control register, so `dtr_n` returns to 1 and the transmitter is disabled.
- R11: `din_ready` is 0 while a character is in flight (`tx_idle` = 0). `tx_idle` returns to 1 after the final stop period has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Bit-clock enable |
| x16_mode | input | 1 | 1 = 16 ticks per bit, 0 = 1 tick per bit |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Control register write value |
| chan_rst | input | 1 | Synchronous channel reset, clears the control register |
| din | input | 8 | Character data |
| din_valid | input | 1 | Data offered |
| din_ready | output | 1 | Data accepted when both valid and ready are high |
| txd | output | 1 | Serial output line |
| dtr_n | output | 1 | Active-low data-terminal-ready |
| tx_idle | output | 1 | No character in flight |
| cfg_err | output | 1 | Half stop bit selected in 1x mode |

## Verification
The bench uses the default `BIT_TICKS` of 16. This makes the 24-tick one-and-a-half stop period, and the 16-tick bit cells around it, directly observable next to the 1x framing. It records the line once per tick and compares the whole record with a frame it builds itself. This covers every length code, both parity senses, parity disabled with the sense bit set, and all four stop codes, in both clock modes. Break and disable are applied in the middle of a 16x character, to show that the character is abandoned and that `txd` and `din_ready` react at once.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int CTL_W   = 9;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] stop;
    logic [1:0] len;
    logic       par_even;
    logic       par_en;
    logic       dtr;
    logic       brk;
    logic       en;
  } ctl_t;

  function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(5);
      2'b01:   return CNT_W'(7);
      2'b10:   return CNT_W'(6);
      default: return CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/async_tx_ctl.sv
module async_tx_ctl
  import async_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic we,
  input  ctl_t wdata,
  output ctl_t ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (chan_rst) ctl_d = '0;
    else if (we)  ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assert_chan_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!ctl_q.dtr && !ctl_q.en));
endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
  import async_tx_pkg::*;
(
  input  ctl_t                ctl,
  input  logic [DATA_W-1:0]   din,
  output logic [FRAME_W-1:0]  frame,
  output logic [CNT_W-1:0]    nbits
);
  logic [CNT_W-1:0]  len;
  logic [DATA_W-1:0] masked;
  logic              par_bit;

  always_comb begin
    len = data_bits(ctl.len);
    for (int i = 0; i < DATA_W; i++)
      masked[i] = (i < int'(len)) ? din[i] : 1'b0;
    par_bit = ctl.par_even ? (^masked) : ~(^masked);
    frame   = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(len)) frame[1+i] = masked[i];
    for (int j = 0; j < FRAME_W; j++)
      if (ctl.par_en && (j == int'(len) + 1)) frame[j] = par_bit;
    nbits = CNT_W'(1) + len + CNT_W'(ctl.par_en)
          + ((ctl.stop == 2'b11) ? CNT_W'(2) : CNT_W'(1));
  end
endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int BIT_TICKS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               x16,
  input  logic               line_ok,
  input  logic               long_stop,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [CNT_W-1:0]   load_nbits,
  input  logic               din_valid,
  output logic               ready,
  output logic               busy,
  output logic               txbit
);
  localparam int LONG_TICKS = BIT_TICKS + BIT_TICKS / 2;
  localparam int SW         = $clog2(LONG_TICKS);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [SW-1:0]      sub_q, sub_d, lim;
  logic               busy_d, x16_q, x16_d, long_q, long_d, accept;

  assign ready  = line_ok && !busy;
  assign accept = ready && din_valid;
  assign txbit  = sr_q[0];

  always_comb begin
    busy_d = busy;
    sr_d   = sr_q;
    left_d = left_q;
    sub_d  = sub_q;
    x16_d  = x16_q;
    long_d = long_q;
    if ((left_q == CNT_W'(1)) && long_q) lim = SW'(LONG_TICKS - 1);
    else if (x16_q)                      lim = SW'(BIT_TICKS - 1);
    else                                 lim = '0;
    if (!line_ok) begin
      busy_d = 1'b0;
      sr_d   = '1;
      sub_d  = '0;
    end else if (accept) begin
      busy_d = 1'b1;
      sr_d   = load_frame;
      left_d = load_nbits;
      sub_d  = '0;
      x16_d  = x16;
      long_d = long_stop && x16;
    end else if (busy && tick) begin
      if (sub_q == lim) begin
        sub_d  = '0;
        sr_d   = {1'b1, sr_q[FRAME_W-1:1]};
        left_d = left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) busy_d = 1'b0;
      end else begin
        sub_d = sub_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sr_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      x16_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      busy   <= busy_d;
      sr_q   <= sr_d;
      left_q <= left_d;
      sub_q  <= sub_d;
      x16_q  <= x16_d;
      long_q <= long_d;
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !txbit));
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && line_ok) |=> $stable(sr_q));
  assert_sub_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sub_q < SW'(LONG_TICKS)));
  assert_one_tick_cells_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !x16_q) |-> (sub_q == '0));
endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
  import async_tx_pkg::*;
#(
  parameter int BIT_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             x16_mode,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             chan_rst,
  input  logic [DATA_W-1:0] din,
  input  logic             din_valid,
  output logic             din_ready,
  output logic             txd,
  output logic             dtr_n,
  output logic             tx_idle,
  output logic             cfg_err
);
  logic [1:0]         rst_sync;
  logic               rst_s_n, busy, txbit, line_on, line_ok;
  ctl_t               ctl;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  async_tx_ctl u_ctl (
    .clk(clk), .rst_n(rst_s_n), .chan_rst(chan_rst),
    .we(ctl_we), .wdata(ctl_t'(ctl_wdata)), .ctl_q(ctl)
  );

  async_tx_frame u_frame (
    .ctl(ctl), .din(din), .frame(frame), .nbits(nbits)
  );

  assign line_on = ctl.en && (ctl.stop != 2'b00);
  assign line_ok = line_on && !ctl.brk;

  async_tx_shift #(.BIT_TICKS(BIT_TICKS)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .x16(x16_mode),
    .line_ok(line_ok), .long_stop(ctl.stop == 2'b10),
    .load_frame(frame), .load_nbits(nbits), .din_valid(din_valid),
    .ready(din_ready), .busy(busy), .txbit(txbit)
  );

  always_comb begin
    if (!line_on)     txd = 1'b1;
    else if (ctl.brk) txd = 1'b0;
    else if (busy)    txd = txbit;
    else              txd = 1'b1;
  end

  assign dtr_n   = ~ctl.dtr;
  assign tx_idle = ~busy;
  assign cfg_err = (ctl.stop == 2'b10) && !x16_mode;

  assert_break_aborts_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctl.brk |=> tx_idle);
  assert_disabled_mark_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctl.en |-> txd);
  assert_ready_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    din_ready |-> tx_idle);
endmodule

// File: tb/async_tx_framer_tb.sv
`timescale 1ns/1ps
module async_tx_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       x16_mode = 1'b0;
  logic       ctl_we = 1'b0;
  logic [8:0] ctl_wdata = '0;
  logic       chan_rst = 1'b0;
  logic [7:0] din = '0;
  logic       din_valid = 1'b0;
  logic       din_ready, txd, dtr_n, tx_idle, cfg_err;

  int n_run = 0, n_fail = 0, tick_gap = 1, tick_cnt = 0;
  bit q_exp[$];
  bit q_got[$];

  async_tx_framer #(.BIT_TICKS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .x16_mode(x16_mode),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .chan_rst(chan_rst),
    .din(din), .din_valid(din_valid), .din_ready(din_ready),
    .txd(txd), .dtr_n(dtr_n), .tx_idle(tx_idle), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    tick_cnt = (tick_cnt + 1 >= tick_gap) ? 0 : tick_cnt + 1;
    tick = (tick_cnt == 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] mk(input logic [1:0] stop, input logic [1:0] len,
                                     input bit pe, input bit pev, input bit dtr,
                                     input bit brk, input bit en);
    return {stop, len, pev, pe, dtr, brk, en};
  endfunction

  task automatic ctl_write(input logic [8:0] v);
    @(negedge clk); ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic push_bits(input bit b, input int n);
    for (int i = 0; i < n; i++) q_exp.push_back(b);
  endtask

  task automatic build_exp(input logic [8:0] cfg, input logic [7:0] d, input bit x16);
    int dur, len, ones;
    dur = x16 ? 16 : 1;
    case (cfg[6:5]) 2'b00: len = 5; 2'b01: len = 7; 2'b10: len = 6; default: len = 8; endcase
    q_exp.delete();
    push_bits(1'b0, dur);
    ones = 0;
    for (int i = 0; i < len; i++) begin
      push_bits(d[i], dur);
      if (d[i]) ones++;
    end
    if (cfg[3]) push_bits(cfg[4] ? bit'(ones % 2) : bit'(1 - ones % 2), dur);
    case (cfg[8:7])
      2'b11:   push_bits(1'b1, 2 * dur);
      2'b10:   push_bits(1'b1, x16 ? 24 : 1);
      default: push_bits(1'b1, dur);
    endcase
  endtask

  task automatic run_frame(input string req, input logic [8:0] cfg,
                           input logic [7:0] d, input bit x16);
    int waited, mism;
    bit rdy_busy;
    x16_mode = x16;
    ctl_write(cfg);
    build_exp(cfg, d, x16);
    q_got.delete();
    din = d; din_valid = 1'b1;
    waited = 0;
    while (!din_ready && waited < 50) begin @(negedge clk); waited++; end
    chk(req, "ready before frame", int'(din_ready), 1);
    @(negedge clk); din_valid = 1'b0;
    rdy_busy = 0;
    for (int k = 0; k < 2000; k++) begin
      if (tx_idle) break;
      if (tick) q_got.push_back(txd);
      if (din_ready) rdy_busy = 1;
      @(negedge clk);
    end
    chk(req, "frame length in ticks", q_got.size(), q_exp.size());
    mism = 0;
    for (int i = 0; i < q_exp.size() && i < q_got.size(); i++)
      if (q_got[i] != q_exp[i]) mism++;
    chk(req, "mismatching tick samples", mism, 0);
    chk("R11", "ready seen while busy", int'(rdy_busy), 0);
    chk("R11", "idle after frame", int'(tx_idle), 1);
    chk(req, "line high after frame", int'(txd), 1);
  endtask

  task automatic t_reset_R1();
    @(negedge clk);
    chk("R1", "txd", int'(txd), 1);
    chk("R1", "dtr_n", int'(dtr_n), 1);
    chk("R1", "tx_idle", int'(tx_idle), 1);
    chk("R1", "din_ready", int'(din_ready), 0);
    chk("R1", "cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_basic_R2();
    run_frame("R2", mk(2'b01, 2'b11, 0, 0, 0, 0, 1), 8'hA5, 0);
    tick_gap = 3;
    run_frame("R2", mk(2'b01, 2'b11, 0, 0, 0, 0, 1), 8'h3C, 0);
    tick_gap = 1;
  endtask

  task automatic t_length_R3();
    run_frame("R3", mk(2'b01, 2'b00, 0, 0, 0, 0, 1), 8'b1110_1011, 0);
    run_frame("R3", mk(2'b01, 2'b01, 0, 0, 0, 0, 1), 8'b1001_0110, 0);
    run_frame("R3", mk(2'b01, 2'b10, 0, 0, 0, 0, 1), 8'b1101_0101, 0);
  endtask

  task automatic t_parity_R4();
    run_frame("R4", mk(2'b01, 2'b11, 1, 1, 0, 0, 1), 8'h17, 0);
    run_frame("R4", mk(2'b01, 2'b11, 1, 0, 0, 0, 1), 8'h17, 0);
    run_frame("R4", mk(2'b01, 2'b00, 1, 0, 0, 0, 1), 8'hE0, 0);
    run_frame("R4", mk(2'b01, 2'b11, 0, 1, 0, 0, 1), 8'h17, 0);
  endtask

  task automatic t_stop_R5();
    int bad;
    run_frame("R5", mk(2'b11, 2'b10, 0, 0, 0, 0, 1), 8'h2A, 0);
    ctl_write(mk(2'b00, 2'b11, 0, 0, 0, 0, 1));
    din_valid = 1'b1; bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (din_ready || !txd || !tx_idle) bad++;
    end
    din_valid = 1'b0;
    chk("R5", "stop code 00 cycles not disabled", bad, 0);
  endtask

  task automatic t_x16_R6();
    run_frame("R6", mk(2'b10, 2'b00, 0, 0, 0, 0, 1), 8'h15, 1);
    run_frame("R6", mk(2'b01, 2'b01, 1, 1, 0, 0, 1), 8'h4B, 1);
  endtask

  task automatic t_cfgerr_R7();
    x16_mode = 1'b0;
    ctl_write(mk(2'b10, 2'b11, 0, 0, 0, 0, 1));
    chk("R7", "cfg_err in 1x half stop", int'(cfg_err), 1);
    run_frame("R7", mk(2'b10, 2'b11, 0, 0, 0, 0, 1), 8'h96, 0);
    x16_mode = 1'b1;
    @(negedge clk);
    chk("R7", "cfg_err in 16x", int'(cfg_err), 0);
  endtask

  task automatic t_break_R8();
    int bad;
    x16_mode = 1'b1;
    ctl_write(mk(2'b01, 2'b11, 0, 0, 0, 0, 1));
    din = 8'hFF; din_valid = 1'b1;
    @(negedge clk); din_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R8", "busy before break", int'(tx_idle), 0);
    ctl_write(mk(2'b01, 2'b11, 0, 0, 0, 1, 1));
    chk("R8", "txd at break", int'(txd), 0);
    din_valid = 1'b1; bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (txd || din_ready) bad++;
    end
    din_valid = 1'b0;
    chk("R8", "break cycles not spacing", bad, 0);
    chk("R8", "frame abandoned", int'(tx_idle), 1);
    ctl_write(mk(2'b01, 2'b11, 0, 0, 0, 0, 1));
    chk("R8", "txd after break", int'(txd), 1);
    chk("R8", "ready after break", int'(din_ready), 1);
  endtask

  task automatic t_disable_R9();
    int bad;
    x16_mode = 1'b1;
    ctl_write(mk(2'b01, 2'b11, 0, 0, 0, 0, 1));
    din = 8'h00; din_valid = 1'b1;
    @(negedge clk); din_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9", "line low mid frame", int'(txd), 0);
    ctl_write(mk(2'b01, 2'b11, 0, 0, 0, 0, 0));
    chk("R9", "txd after disable", int'(txd), 1);
    din_valid = 1'b1; bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!txd || din_ready || !tx_idle) bad++;
    end
    din_valid = 1'b0;
    chk("R9", "disabled cycles wrong", bad, 0);
  endtask

  task automatic t_dtr_R10();
    ctl_write(mk(2'b01, 2'b11, 0, 0, 1, 0, 1));
    chk("R10", "dtr_n with bit set", int'(dtr_n), 0);
    ctl_write(mk(2'b01, 2'b11, 0, 0, 0, 0, 1));
    chk("R10", "dtr_n with bit clear", int'(dtr_n), 1);
    ctl_write(mk(2'b01, 2'b11, 0, 0, 1, 0, 1));
    @(negedge clk); chan_rst = 1'b1;
    @(negedge clk); chan_rst = 1'b0;
    chk("R10", "dtr_n after channel reset", int'(dtr_n), 1);
    chk("R10", "ready after channel reset", int'(din_ready), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_R1();
    t_basic_R2();
    t_length_R3();
    t_parity_R4();
    t_stop_R5();
    t_x16_R6();
    t_cfgerr_R7();
    t_break_R8();
    t_disable_R9();
    t_dtr_R10();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule